// File: doc/BRIEF.md
# Interlaced YCbCr 4:2:2 Video Output Formatter

This block turns a stream of 8-bit YCbCr 4:2:2 pixels into an interlaced digital video bus with embedded timing reference codes. It generates its own line and field timing for four interlaced formats: 525-line and 625-line standard definition, and the 60 Hz and 50 Hz 1080-line high-definition formats. Each line starts with an end-of-active-video code, continues with blanking filled with the defined blank levels, then a start-of-active-video code, then active samples. Vertical blanking lines carry the blank levels through the whole active region, so the bus never keeps the last data value.

Two bus modes share one 16-bit output. In the narrow mode, chroma and luma are multiplexed on the low byte in the order Cb, Y, Cr, Y. In the wide mode, luma goes on the upper lane and chroma on the lower lane, and timing codes are repeated on both lanes. Active samples are fetched through a request pin. The format and the bus mode may be changed while running, and each change takes effect at the next frame start. Separate horizontal and vertical sync pins can be enabled by a parameter. These pins are in addition to the embedded codes.

The geometry of each format is set by parameter arrays. These give the active pixels and blanking pixels per line, and the blank and active line counts of each field. The word counters are sized from the largest format, so blanking of several hundred pixels is handled.

Top module: `ilace_vid_tx`

## Requirements
- R1: While reset is high, vid_q is 0x0000, hs_q and vs_q are 0 and px_req is 0. After reset the block starts line 0, word 0 of a frame in format 0 (525-line), narrow mode.
- R2: A line has B blanking words followed by A active words. In narrow mode B = 2*H_BLK and A = 2*H_ACT; in wide mode B = H_BLK and A = H_ACT. The words of a line cycle produce vid_q one clock later.
- R3: Words 0..3 of a line carry the end code and words B-4..B-1 carry the start code. Each code is 0xFF, 0x00, 0x00, XY, where XY = {1, F, V, H, V^H, F^H, F^V, F^V^H}, with H=1 in the end code and H=0 in the start code. In narrow mode the code is on vid_q[7:0] with vid_q[15:8]=0; in wide mode it is on both bytes.
- R4: A frame is V_BLK1 blank lines and V_ACT active lines with F=0, then V_BLK2 blank lines and V_ACT active lines with F=1. V=1 on blank lines.
- R5: Narrow mode, active line. On even active words px_req=1, and the next vid_q[7:0] is px_c while px_y is held. On odd active words px_req=0, and the next vid_q[7:0] is the held px_y. vid_q[15:8] is 0 throughout. A pixel is consumed at each rising edge with px_req=1. px_c carries Cb for even pixels and Cr for odd pixels.
- R6: Wide mode, active line. px_req=1 on every active word, and the next vid_q is {px_y, px_c}.
- R7: An active data sample of 0x00 is output as 0x01, and one of 0xFF is output as 0xFE.
- R8: Blanking words that are not code words, and the whole active region of blank lines, carry blank levels. In narrow mode this is 0x80 on even line words and 0x10 on odd ones. In wide mode it is 0x1080.
- R9: fmt_sel (0: 525-line, 1: 625-line, 2: 1080-line 60 Hz, 3: 1080-line 50 Hz) and wide_sel (1 = wide) are sampled only at the edge that ends the last word of a frame. A change in mid-frame has no effect until then.
- R10: With SYNC_EN=1, hs_q is 1 on the B blanking words and vs_q is 1 on blank lines, aligned with vid_q. With SYNC_EN=0 both stay 0.
- R11: Horizontal blanking longer than 255 pixels, up to the default 720, is timed exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel word clock |
| rst | input | 1 | Synchronous reset, active high |
| fmt_sel | input | 2 | Requested format, applied at next frame start |
| wide_sel | input | 1 | Requested bus mode (1 = 16-bit dual lane), applied at next frame start |
| px_y | input | 8 | Luma of the current pixel |
| px_c | input | 8 | Chroma of the current pixel (Cb even, Cr odd) |
| px_req | output | 1 | Current pixel is consumed at this rising edge |
| vid_q | output | 16 | Video bus; narrow mode uses bits 7:0 |
| hs_q | output | 1 | Horizontal blanking indicator |
| vs_q | output | 1 | Vertical blanking indicator |

## Verification
The bench builds the block with shrunken geometry, 4 to 8 active pixels and 1 to 3 lines per region, so that it can run eight whole frames and change format or bus mode once per frame in mid-frame. Format 3 keeps a 300-pixel blanking interval, which exercises the wide counters of R11 in both bus modes. An odd 9-pixel blanking in wide mode tests code placement when it is not aligned to a word pair. SYNC_EN is 1, and the pixel source produces 0x00 and 0xFF often enough to exercise clipping on both lanes.

// File: rtl/vtx_pkg.sv
package vtx_pkg;

  localparam int NFMT = 4;
  localparam logic [7:0] LVL_C = 8'h80;
  localparam logic [7:0] LVL_Y = 8'h10;

  // protected status word of a timing code
  function automatic logic [7:0] trs_xy(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  // word of a four-word timing code at position pos
  function automatic logic [7:0] code_word(input logic [1:0] pos, input logic f,
                                           input logic v, input logic h);
    logic [7:0] w;
    case (pos)
      2'd0:    w = 8'hFF;
      2'd1:    w = 8'h00;
      2'd2:    w = 8'h00;
      default: w = trs_xy(f, v, h);
    endcase
    return w;
  endfunction

  // keep data out of the reserved code values
  function automatic logic [7:0] clip_smp(input logic [7:0] s);
    logic [7:0] r;
    if (s == 8'h00)      r = 8'h01;
    else if (s == 8'hFF) r = 8'hFE;
    else                 r = s;
    return r;
  endfunction

endpackage

// File: rtl/vtx_timing.sv
module vtx_timing import vtx_pkg::*; #(
  parameter int unsigned H_ACT  [NFMT] = '{720, 720, 1920, 1920},
  parameter int unsigned H_BLK  [NFMT] = '{138, 144, 280, 720},
  parameter int unsigned V_BLK1 [NFMT] = '{22, 24, 22, 22},
  parameter int unsigned V_ACT  [NFMT] = '{240, 288, 540, 540},
  parameter int unsigned V_BLK2 [NFMT] = '{23, 25, 23, 23},
  parameter int HW = 13,
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    fmt_sel,
  input  logic          wide_sel,
  output logic [1:0]    cur_fmt,
  output logic          cur_wide,
  output logic [HW-1:0] h_cnt,
  output logic [HW-1:0] blk_words,
  output logic [LW-1:0] line_cnt,
  output logic          f_bit,
  output logic          v_bit,
  output logic          frame_wrap
);

  // per-format geometry tables
  logic [HW-1:0] blk_n  [NFMT];
  logic [HW-1:0] blk_w  [NFMT];
  logic [HW-1:0] len_n  [NFMT];
  logic [HW-1:0] len_w  [NFMT];
  logic [LW-1:0] act1_ln[NFMT];
  logic [LW-1:0] fld2_ln[NFMT];
  logic [LW-1:0] act2_ln[NFMT];
  logic [LW-1:0] last_ln[NFMT];

  for (genvar g = 0; g < NFMT; g++) begin : g_fmt
    assign blk_n[g]   = HW'(2 * H_BLK[g]);
    assign blk_w[g]   = HW'(H_BLK[g]);
    assign len_n[g]   = HW'(2 * (H_ACT[g] + H_BLK[g]));
    assign len_w[g]   = HW'(H_ACT[g] + H_BLK[g]);
    assign act1_ln[g] = LW'(V_BLK1[g]);
    assign fld2_ln[g] = LW'(V_BLK1[g] + V_ACT[g]);
    assign act2_ln[g] = LW'(V_BLK1[g] + V_ACT[g] + V_BLK2[g]);
    assign last_ln[g] = LW'(V_BLK1[g] + 2 * V_ACT[g] + V_BLK2[g] - 1);
  end

  logic [HW-1:0] line_len;
  logic          line_end;

  always_comb begin
    blk_words = cur_wide ? blk_w[cur_fmt] : blk_n[cur_fmt];
    line_len  = cur_wide ? len_w[cur_fmt] : len_n[cur_fmt];
    line_end  = (h_cnt == line_len - HW'(1));
    frame_wrap = line_end && (line_cnt == last_ln[cur_fmt]);
    f_bit     = (line_cnt >= fld2_ln[cur_fmt]);
    v_bit     = (line_cnt < act1_ln[cur_fmt]) ||
                ((line_cnt >= fld2_ln[cur_fmt]) && (line_cnt < act2_ln[cur_fmt]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_cnt    <= '0;
      line_cnt <= '0;
      cur_fmt  <= 2'd0;
      cur_wide <= 1'b0;
    end else if (frame_wrap) begin
      h_cnt    <= '0;
      line_cnt <= '0;
      cur_fmt  <= fmt_sel;
      cur_wide <= wide_sel;
    end else if (line_end) begin
      h_cnt    <= '0;
      line_cnt <= line_cnt + LW'(1);
    end else begin
      h_cnt    <= h_cnt + HW'(1);
    end
  end

endmodule

// File: rtl/vtx_mux.sv
module vtx_mux import vtx_pkg::*; #(
  parameter int HW = 13,
  parameter bit SYNC_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cur_wide,
  input  logic [HW-1:0] h_cnt,
  input  logic [HW-1:0] blk_words,
  input  logic          f_bit,
  input  logic          v_bit,
  input  logic [7:0]    px_y,
  input  logic [7:0]    px_c,
  output logic          px_req,
  output logic          code_slot,
  output logic [1:0]    code_pos,
  output logic          act_slot,
  output logic [15:0]   vid_q,
  output logic          hs_q,
  output logic          vs_q
);

  logic          in_eav;
  logic          in_sav;
  logic [HW-1:0] sav_base;
  logic [HW-1:0] sav_off;
  logic [HW-1:0] act_idx;
  logic          live;
  logic [7:0]    cw;
  logic [7:0]    y_hold;

  always_comb begin
    sav_base  = blk_words - HW'(4);
    sav_off   = h_cnt - sav_base;
    act_idx   = h_cnt - blk_words;
    in_eav    = (h_cnt < HW'(4));
    in_sav    = (h_cnt >= sav_base) && (h_cnt < blk_words);
    code_slot = in_eav || in_sav;
    code_pos  = in_eav ? h_cnt[1:0] : sav_off[1:0];
    act_slot  = (h_cnt >= blk_words);
    live      = act_slot && !v_bit;
    px_req    = live && (cur_wide || !act_idx[0]);
    cw        = code_word(code_pos, f_bit, v_bit, in_eav);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vid_q  <= '0;
      y_hold <= '0;
    end else if (code_slot) begin
      vid_q <= cur_wide ? {cw, cw} : {8'h00, cw};
    end else if (live) begin
      if (cur_wide) begin
        vid_q <= {clip_smp(px_y), clip_smp(px_c)};
      end else if (!act_idx[0]) begin
        vid_q  <= {8'h00, clip_smp(px_c)};
        y_hold <= px_y;
      end else begin
        vid_q <= {8'h00, clip_smp(y_hold)};
      end
    end else begin
      vid_q <= cur_wide ? {LVL_Y, LVL_C} : {8'h00, (h_cnt[0] ? LVL_Y : LVL_C)};
    end
  end

  if (SYNC_EN) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) begin
        hs_q <= 1'b0;
        vs_q <= 1'b0;
      end else begin
        hs_q <= !act_slot;
        vs_q <= v_bit;
      end
    end
  end else begin : g_nosync
    assign hs_q = 1'b0;
    assign vs_q = 1'b0;
  end

endmodule

// File: rtl/ilace_vid_tx.sv
module ilace_vid_tx import vtx_pkg::*; #(
  parameter int unsigned H_ACT  [NFMT] = '{720, 720, 1920, 1920},
  parameter int unsigned H_BLK  [NFMT] = '{138, 144, 280, 720},
  parameter int unsigned V_BLK1 [NFMT] = '{22, 24, 22, 22},
  parameter int unsigned V_ACT  [NFMT] = '{240, 288, 540, 540},
  parameter int unsigned V_BLK2 [NFMT] = '{23, 25, 23, 23},
  parameter bit SYNC_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  fmt_sel,
  input  logic        wide_sel,
  input  logic [7:0]  px_y,
  input  logic [7:0]  px_c,
  output logic        px_req,
  output logic [15:0] vid_q,
  output logic        hs_q,
  output logic        vs_q
);

  function automatic int unsigned widest_line();
    int unsigned m = 0;
    for (int i = 0; i < NFMT; i++)
      if (2 * (H_ACT[i] + H_BLK[i]) > m) m = 2 * (H_ACT[i] + H_BLK[i]);
    return m;
  endfunction

  function automatic int unsigned tallest_frame();
    int unsigned m = 0;
    for (int i = 0; i < NFMT; i++)
      if (V_BLK1[i] + 2 * V_ACT[i] + V_BLK2[i] > m) m = V_BLK1[i] + 2 * V_ACT[i] + V_BLK2[i];
    return m;
  endfunction

  localparam int HW = $clog2(widest_line() + 1);
  localparam int LW = $clog2(tallest_frame() + 1);

  // named internal events
  logic [1:0]    cur_fmt;
  logic          cur_wide;
  logic [HW-1:0] h_cnt;
  logic [HW-1:0] blk_words;
  logic [LW-1:0] line_cnt;
  logic          f_bit;
  logic          blank_line;
  logic          frame_wrap;
  logic          code_slot;
  logic [1:0]    code_pos;
  logic          act_slot;

  vtx_timing #(
    .H_ACT(H_ACT), .H_BLK(H_BLK), .V_BLK1(V_BLK1), .V_ACT(V_ACT), .V_BLK2(V_BLK2),
    .HW(HW), .LW(LW)
  ) u_timing (
    .clk(clk), .rst(rst), .fmt_sel(fmt_sel), .wide_sel(wide_sel),
    .cur_fmt(cur_fmt), .cur_wide(cur_wide), .h_cnt(h_cnt), .blk_words(blk_words),
    .line_cnt(line_cnt), .f_bit(f_bit), .v_bit(blank_line), .frame_wrap(frame_wrap)
  );

  vtx_mux #(.HW(HW), .SYNC_EN(SYNC_EN)) u_mux (
    .clk(clk), .rst(rst), .cur_wide(cur_wide), .h_cnt(h_cnt), .blk_words(blk_words),
    .f_bit(f_bit), .v_bit(blank_line), .px_y(px_y), .px_c(px_c), .px_req(px_req),
    .code_slot(code_slot), .code_pos(code_pos), .act_slot(act_slot),
    .vid_q(vid_q), .hs_q(hs_q), .vs_q(vs_q)
  );

endmodule

// File: rtl/vtx_chk.sv
module vtx_chk #(
  parameter bit SYNC_EN = 1'b1
) (
  input logic        clk,
  input logic        rst,
  input logic        px_req,
  input logic [15:0] vid_q,
  input logic        hs_q,
  input logic        code_slot,
  input logic [1:0]  code_pos,
  input logic        act_slot,
  input logic        blank_line,
  input logic        cur_wide
);

  assert_req_in_active_R5: assert property (@(posedge clk) disable iff (rst)
    px_req |-> (act_slot && !blank_line));

  assert_pair_req_R5: assert property (@(posedge clk) disable iff (rst)
    (px_req && !cur_wide) |=> !px_req);

  assert_upper_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !cur_wide |=> (vid_q[15:8] == 8'h00));

  assert_lead_ff_R3: assert property (@(posedge clk) disable iff (rst)
    (code_slot && code_pos == 2'd0) |=> (vid_q[7:0] == 8'hFF));

  assert_xy_msb_R3: assert property (@(posedge clk) disable iff (rst)
    (code_slot && code_pos == 2'd3) |=> vid_q[7]);

  assert_no_reserved_R7: assert property (@(posedge clk) disable iff (rst)
    (act_slot && !blank_line) |=> (vid_q[7:0] != 8'h00 && vid_q[7:0] != 8'hFF));

  assert_blank_level_R8: assert property (@(posedge clk) disable iff (rst)
    (!cur_wide && !code_slot && (blank_line || !act_slot)) |=>
      (vid_q[7:0] == 8'h80 || vid_q[7:0] == 8'h10));

  if (SYNC_EN) begin : g_hs
    assert_hs_codes_R10: assert property (@(posedge clk) disable iff (rst)
      code_slot |=> hs_q);
  end

endmodule

bind ilace_vid_tx vtx_chk #(.SYNC_EN(SYNC_EN)) u_vtx_chk (
  .clk(clk), .rst(rst), .px_req(px_req), .vid_q(vid_q), .hs_q(hs_q),
  .code_slot(code_slot), .code_pos(code_pos), .act_slot(act_slot),
  .blank_line(blank_line), .cur_wide(cur_wide)
);

// File: tb/tb_ilace_vid_tx.sv
module tb_ilace_vid_tx;

  localparam int unsigned TB_HA [4] = '{6, 8, 4, 4};
  localparam int unsigned TB_HB [4] = '{10, 12, 9, 300};
  localparam int unsigned TB_VB1[4] = '{2, 3, 1, 2};
  localparam int unsigned TB_VA [4] = '{3, 2, 2, 2};
  localparam int unsigned TB_VB2[4] = '{3, 2, 2, 1};
  localparam int WD_CYC = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  fmt_sel = 2'd0;
  logic        wide_sel = 1'b0;
  logic [7:0]  px_y = 8'h00;
  logic [7:0]  px_c = 8'h00;
  logic        px_req;
  logic [15:0] vid_q;
  logic        hs_q;
  logic        vs_q;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ilace_vid_tx #(
    .H_ACT(TB_HA), .H_BLK(TB_HB), .V_BLK1(TB_VB1), .V_ACT(TB_VA), .V_BLK2(TB_VB2),
    .SYNC_EN(1'b1)
  ) dut (
    .clk(clk), .rst(rst), .fmt_sel(fmt_sel), .wide_sel(wide_sel),
    .px_y(px_y), .px_c(px_c), .px_req(px_req), .vid_q(vid_q), .hs_q(hs_q), .vs_q(vs_q)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%04h expected 0x%04h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] gen_y(input int n);
    if (n % 7 == 0) return 8'h00;
    if (n % 7 == 3) return 8'hFF;
    return 8'((n * 53 + 17) % 256);
  endfunction

  function automatic logic [7:0] gen_c(input int n);
    if (n % 5 == 1) return 8'hFF;
    if (n % 5 == 4) return 8'h00;
    return 8'((n * 71 + 5) % 256);
  endfunction

  function automatic logic [7:0] lim(input logic [7:0] s);
    if (s == 8'h00) return 8'h01;
    if (s == 8'hFF) return 8'hFE;
    return s;
  endfunction

  // model state
  int m_fmt = 0, m_wide = 0, m_h = 0, m_line = 0, n_pix = 0, frames = 0;
  int sched_i = 0, clip_seen = 0;
  int combo_seen [8];
  logic [7:0] m_hold = 8'h00;
  logic [15:0] e_vid;
  logic e_hs, e_vs, e_req;
  string e_tag;

  initial begin
    int sch_f [7] = '{1, 2, 3, 0, 3, 1, 2};
    int sch_w [7] = '{0, 1, 1, 1, 0, 1, 0};
    for (int i = 0; i < 8; i++) combo_seen[i] = 0;
    repeat (3) @(negedge clk);
    check("R1 vid_q in reset", vid_q, 16'h0000);
    check("R1 hs_q in reset", {15'd0, hs_q}, 16'd0);
    check("R1 vs_q in reset", {15'd0, vs_q}, 16'd0);
    check("R1 px_req in reset", {15'd0, px_req}, 16'd0);
    rst = 1'b0;
    while (frames < 8) begin
      int blk, len, a1, f2, a2, last, pos, idx, fb, vb, hb;
      logic [7:0] b, xy, ys, cs;
      blk  = m_wide ? TB_HB[m_fmt] : 2 * TB_HB[m_fmt];
      len  = blk + (m_wide ? TB_HA[m_fmt] : 2 * TB_HA[m_fmt]);
      a1   = TB_VB1[m_fmt];
      f2   = a1 + TB_VA[m_fmt];
      a2   = f2 + TB_VB2[m_fmt];
      last = a2 + TB_VA[m_fmt] - 1;
      fb   = (m_line >= f2) ? 1 : 0;
      vb   = (m_line < a1 || (m_line >= f2 && m_line < a2)) ? 1 : 0;
      combo_seen[m_fmt * 2 + m_wide] = 1;
      // mid-frame request for the next frame's format (R9)
      if (m_line == 1 && m_h == 0 && sched_i < 7) begin
        fmt_sel  = 2'(sch_f[sched_i]);
        wide_sel = (sch_w[sched_i] != 0);
        sched_i++;
      end
      px_y = gen_y(n_pix);
      px_c = gen_c(n_pix);
      e_req = 1'b0;
      if (m_h < 4 || (m_h >= blk - 4 && m_h < blk)) begin
        pos = (m_h < 4) ? m_h : m_h - (blk - 4);
        hb  = (m_h < 4) ? 1 : 0;
        xy  = 8'(128 + fb * 64 + vb * 32 + hb * 16 + (vb ^ hb) * 8 + (fb ^ hb) * 4 +
                 (fb ^ vb) * 2 + (fb ^ vb ^ hb));
        b   = (pos == 0) ? 8'hFF : ((pos < 3) ? 8'h00 : xy);
        e_vid = m_wide ? {b, b} : {8'h00, b};
        e_tag = "R2,R3,R4 code word";
      end else if (m_h >= blk && vb == 0) begin
        idx = m_h - blk;
        if (m_wide != 0) begin
          ys = px_y; cs = px_c;
          e_vid = {lim(ys), lim(cs)};
          e_req = 1'b1;
          e_tag = "R6 wide active";
          if (ys == 8'h00 || ys == 8'hFF || cs == 8'h00 || cs == 8'hFF) begin
            clip_seen++; e_tag = "R6,R7 wide active clip";
          end
        end else if (idx % 2 == 0) begin
          cs = px_c;
          e_vid = {8'h00, lim(cs)};
          m_hold = px_y;
          e_req = 1'b1;
          e_tag = (cs == 8'h00 || cs == 8'hFF) ? "R5,R7 chroma clip" : "R5 chroma";
          if (cs == 8'h00 || cs == 8'hFF) clip_seen++;
        end else begin
          e_vid = {8'h00, lim(m_hold)};
          e_tag = (m_hold == 8'h00 || m_hold == 8'hFF) ? "R5,R7 luma clip" : "R5 luma";
          if (m_hold == 8'h00 || m_hold == 8'hFF) clip_seen++;
        end
      end else begin
        e_vid = m_wide ? 16'h1080 : {8'h00, (m_h % 2 == 0) ? 8'h80 : 8'h10};
        e_tag = vb ? "R4,R8 vertical blank level" : "R8 horizontal blank level";
      end
      if (m_fmt == 3) e_tag = {e_tag, " R11"};
      if (frames > 0 && m_line == 0) e_tag = {e_tag, " R9"};
      e_hs = (m_h < blk);
      e_vs = (vb != 0);
      check({"R5,R6 px_req ", e_tag}, {15'd0, px_req}, {15'd0, e_req});
      if (e_req) n_pix++;
      // advance model
      if (m_h == len - 1) begin
        m_h = 0;
        if (m_line == last) begin
          m_line = 0; m_fmt = int'(fmt_sel); m_wide = wide_sel ? 1 : 0; frames++;
        end else m_line++;
      end else m_h++;
      @(negedge clk);
      check(e_tag, vid_q, e_vid);
      check({"R10 hs_q ", e_tag}, {15'd0, hs_q}, {15'd0, e_hs});
      check({"R10 vs_q ", e_tag}, {15'd0, vs_q}, {15'd0, e_vs});
    end
    check("R7 clipped samples seen", {15'd0, clip_seen > 0}, 16'd1);
    check("R9 format 3 narrow frame seen", 16'(combo_seen[6]), 16'd1);
    check("R9 format 3 wide frame seen", 16'(combo_seen[7]), 16'd1);
    check("R9 format 2 wide frame seen", 16'(combo_seen[5]), 16'd1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(WD_CYC * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got no end after %0d cycles expected completion", WD_CYC);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule